// File: doc/BRIEF.md
# Link Speed Retrain Sequencer

This block runs once after reset and brings a serial link up to its best supported rate. If the link is up and able to run faster than the base rate, but is running at the base rate, the block requests retraining. It then waits for training to finish and for the link state machine to return to its active state. It sees the link only through two things: a 5-bit link state input, and a simple request/acknowledge register port. Over that port it reads and writes three 16-bit fields of the standard link capability structure, which sits at byte address 0x80 of configuration space.

When it has finished, the sequencer raises `done` and holds it. Each of its two waits has its own deadline, and each has its own sticky error flag. An expired training deadline does not stop the sequence: the block still goes on to wait for the active state. Poll spacing and deadline length are parameters counted in clock cycles. At 100 MHz the defaults give polls about 100 µs apart and deadlines of about one second.

Top module: `link_retrain_seq`

## Requirements
- R1: At the first cycle after reset the block samples `ltssm_state`. If the value is not 5'h0F (the active state), the block raises `done` and never issues a register access.
- R2: With the link active, the first access is a read of byte address 0x08C (link capability). If bits [3:0] of the returned data are 1 (2.5 GT/s) or less, the block raises `done` without any write.
- R3: If the supported speed is above 1, the block reads address 0x092 (link status). It goes on toward retraining only when status bits [3:0] equal 1. Any other value ends the sequence with no write.
- R4: Retraining is a read of address 0x090 (link control) followed by a write to 0x090. The write carries the read value with bit 5 (retrain) set and every other bit unchanged. It is the only write the block ever makes.
- R5: `bus_req` stays high, with `bus_we`, `bus_addr` and `bus_wdata` stable, until the cycle in which `bus_ack` is sampled high. Only one access is outstanding at a time, and `bus_rdata` is taken in the acknowledge cycle.
- R6: After the write, the block reads 0x092 repeatedly until status bit 11 (link training) reads 0. It then waits for the active state with no training error. The number of status reads in this phase is one more than the number of reads that return bit 11 set.
- R7: Suppose a training poll still returns bit 11 set, and at least TIMEOUT cycles have passed since the training phase began. The block then sets `err_train_timeout`, which stays set, and moves on to the active-state wait. No earlier poll can set it.
- R8: In the active-state wait, the block raises `done` as soon as a check sees `ltssm_state` equal to 5'h0F. If a check fails after TIMEOUT cycles of the wait, the block sets `err_l0_timeout` and raises `done` in the same cycle.
- R9: Within one wait phase, the start of each poll is at least POLL_GAP cycles after the start of the one before it.
- R10: Once `done` is high it stays high until reset, and the block issues no further register access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; the sequence starts when it falls |
| ltssm_state | input | 5 | Current link training state; 5'h0F is the active state |
| bus_req | output | 1 | Register access request, held until acknowledged |
| bus_we | output | 1 | 1 = write, 0 = read |
| bus_addr | output | 12 | Byte address in configuration space |
| bus_wdata | output | 16 | Write data |
| bus_ack | input | 1 | One-cycle acknowledge of the pending access |
| bus_rdata | input | 16 | Read data, valid when `bus_ack` is high |
| done | output | 1 | Sequence finished (sticky) |
| err_train_timeout | output | 1 | Training did not finish in time (sticky) |
| err_l0_timeout | output | 1 | Link did not return to the active state in time (sticky) |

## Verification
The hardest cases to reach are the two deadline paths. Each needs the link to stay stuck for a whole timeout after a retrain write that only happens when speed fields line up. The bench builds the DUT with a short poll gap and deadline. Its register model reports link training as active for a programmed number of status reads, which can be unbounded, and it holds the link state off 5'h0F for a programmed time after the write, which can be forever. The bench measures the cycles from the write acknowledge to the error flag, and the spacing between polls. A sweep over every supported/current speed pair, with the link both up and down, covers all the skip decisions.

// File: rtl/retrain_pkg.sv
package retrain_pkg;

    localparam int ADDR_W = 12;
    localparam int DATA_W = 16;

    localparam logic [ADDR_W-1:0] CAP_BASE  = 12'h080;
    localparam logic [ADDR_W-1:0] A_LNK_CAP = CAP_BASE + 12'h00C;
    localparam logic [ADDR_W-1:0] A_LNK_CTL = CAP_BASE + 12'h010;
    localparam logic [ADDR_W-1:0] A_LNK_STA = CAP_BASE + 12'h012;

    localparam logic [4:0] LINK_ACTIVE   = 5'h0F;
    localparam logic [3:0] SPEED_BASE    = 4'd1;
    localparam int         RETRAIN_BIT   = 5;
    localparam int         TRAINING_BIT  = 11;

    typedef struct packed {
        logic              we;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
    } bus_op_t;

    typedef enum logic [3:0] {
        ST_BOOT,
        ST_CAP,
        ST_STA,
        ST_CTL,
        ST_WR,
        ST_TRN_RD,
        ST_TRN_GAP,
        ST_L0_CHK,
        ST_L0_GAP,
        ST_DONE
    } seq_state_t;

    function automatic bus_op_t rd_op(input logic [ADDR_W-1:0] a);
        bus_op_t o;
        o.we    = 1'b0;
        o.addr  = a;
        o.wdata = '0;
        return o;
    endfunction

    function automatic bus_op_t wr_op(input logic [ADDR_W-1:0] a,
                                      input logic [DATA_W-1:0] d);
        bus_op_t o;
        o.we    = 1'b1;
        o.addr  = a;
        o.wdata = d;
        return o;
    endfunction

    function automatic logic link_active(input logic [4:0] s);
        return s == LINK_ACTIVE;
    endfunction

endpackage

// File: rtl/retrain_busport.sv
module retrain_busport
    import retrain_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  bus_op_t           op,
    output logic              xfer_done,
    output logic [DATA_W-1:0] rdata_q,
    output logic              bus_req,
    output logic              bus_we,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_ack,
    input  logic [DATA_W-1:0] bus_rdata
);

    bus_op_t op_q;
    logic    req_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            req_q     <= 1'b0;
            op_q      <= '0;
            xfer_done <= 1'b0;
            rdata_q   <= '0;
        end else begin
            xfer_done <= 1'b0;
            if (req_q && bus_ack) begin
                req_q     <= 1'b0;
                xfer_done <= 1'b1;
                rdata_q   <= bus_rdata;
            end else if (start && !req_q) begin
                req_q <= 1'b1;
                op_q  <= op;
            end
        end
    end

    assign bus_req   = req_q;
    assign bus_we    = op_q.we;
    assign bus_addr  = op_q.addr;
    assign bus_wdata = op_q.wdata;

endmodule

// File: rtl/retrain_timer.sv
module retrain_timer #(
    parameter int unsigned LIMIT = 1
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    output logic reached
);

    localparam int W = $clog2(LIMIT + 2);
    localparam logic [W-1:0] LIM = W'(LIMIT);

    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt <= '0;
        end else if (cnt < LIM) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign reached = (cnt == LIM);

endmodule

// File: rtl/link_retrain_seq.sv
module link_retrain_seq
    import retrain_pkg::*;
#(
    parameter int unsigned POLL_GAP = 10000,
    parameter int unsigned TIMEOUT  = 100000000
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [4:0]  ltssm_state,
    output logic        bus_req,
    output logic        bus_we,
    output logic [11:0] bus_addr,
    output logic [15:0] bus_wdata,
    input  logic        bus_ack,
    input  logic [15:0] bus_rdata,
    output logic        done,
    output logic        err_train_timeout,
    output logic        err_l0_timeout
);

    localparam int unsigned GAP_LIMIT = (POLL_GAP > 0) ? POLL_GAP - 1 : 0;
    localparam logic [DATA_W-1:0] RETRAIN_MASK = DATA_W'(1) << RETRAIN_BIT;

    seq_state_t        st;
    logic              start;
    bus_op_t           op;
    logic              bp_done;
    logic [DATA_W-1:0] bp_rdata;
    logic              gap_clr, gap_reached;
    logic              dl_clr, dl_reached, dl_expired;

    retrain_busport u_port (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .op        (op),
        .xfer_done (bp_done),
        .rdata_q   (bp_rdata),
        .bus_req   (bus_req),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_ack   (bus_ack),
        .bus_rdata (bus_rdata)
    );

    assign gap_clr = !(st == ST_TRN_GAP || st == ST_L0_GAP);

    retrain_timer #(.LIMIT(GAP_LIMIT)) u_gap (
        .clk     (clk),
        .rst     (rst),
        .clr     (gap_clr),
        .reached (gap_reached)
    );

    retrain_timer #(.LIMIT(TIMEOUT)) u_deadline (
        .clk     (clk),
        .rst     (rst),
        .clr     (dl_clr),
        .reached (dl_reached)
    );

    assign dl_expired = dl_reached && !dl_clr;

    always_ff @(posedge clk) begin
        if (rst) begin
            st                <= ST_BOOT;
            start             <= 1'b0;
            op                <= '0;
            dl_clr            <= 1'b1;
            err_train_timeout <= 1'b0;
            err_l0_timeout    <= 1'b0;
        end else begin
            start  <= 1'b0;
            dl_clr <= 1'b0;
            unique case (st)
                ST_BOOT: begin
                    if (link_active(ltssm_state)) begin
                        start <= 1'b1;
                        op    <= rd_op(A_LNK_CAP);
                        st    <= ST_CAP;
                    end else begin
                        st <= ST_DONE;
                    end
                end
                ST_CAP: if (bp_done) begin
                    if (bp_rdata[3:0] > SPEED_BASE) begin
                        start <= 1'b1;
                        op    <= rd_op(A_LNK_STA);
                        st    <= ST_STA;
                    end else begin
                        st <= ST_DONE;
                    end
                end
                ST_STA: if (bp_done) begin
                    if (bp_rdata[3:0] == SPEED_BASE) begin
                        start <= 1'b1;
                        op    <= rd_op(A_LNK_CTL);
                        st    <= ST_CTL;
                    end else begin
                        st <= ST_DONE;
                    end
                end
                ST_CTL: if (bp_done) begin
                    start <= 1'b1;
                    op    <= wr_op(A_LNK_CTL, bp_rdata | RETRAIN_MASK);
                    st    <= ST_WR;
                end
                ST_WR: if (bp_done) begin
                    start  <= 1'b1;
                    op     <= rd_op(A_LNK_STA);
                    dl_clr <= 1'b1;
                    st     <= ST_TRN_RD;
                end
                ST_TRN_RD: if (bp_done) begin
                    if (!bp_rdata[TRAINING_BIT]) begin
                        dl_clr <= 1'b1;
                        st     <= ST_L0_CHK;
                    end else if (dl_expired) begin
                        err_train_timeout <= 1'b1;
                        dl_clr            <= 1'b1;
                        st                <= ST_L0_CHK;
                    end else begin
                        st <= ST_TRN_GAP;
                    end
                end
                ST_TRN_GAP: if (gap_reached) begin
                    start <= 1'b1;
                    op    <= rd_op(A_LNK_STA);
                    st    <= ST_TRN_RD;
                end
                ST_L0_CHK: begin
                    if (link_active(ltssm_state)) begin
                        st <= ST_DONE;
                    end else if (dl_expired) begin
                        err_l0_timeout <= 1'b1;
                        st             <= ST_DONE;
                    end else begin
                        st <= ST_L0_GAP;
                    end
                end
                ST_L0_GAP: if (gap_reached) st <= ST_L0_CHK;
                ST_DONE: st <= ST_DONE;
                default: st <= ST_DONE;
            endcase
        end
    end

    assign done = (st == ST_DONE);

endmodule

// File: rtl/link_retrain_seq_chk.sv
module link_retrain_seq_chk (
    input logic        clk,
    input logic        rst,
    input logic        bus_req,
    input logic        bus_we,
    input logic [11:0] bus_addr,
    input logic [15:0] bus_wdata,
    input logic        bus_ack,
    input logic        done,
    input logic        err_train_timeout,
    input logic        err_l0_timeout
);

    p_hold_r5: assert property (@(posedge clk) disable iff (rst)
        bus_req && !bus_ack |=> bus_req && $stable(bus_we) &&
                                $stable(bus_addr) && $stable(bus_wdata));

    p_write_target_r4: assert property (@(posedge clk) disable iff (rst)
        bus_req && bus_we |-> bus_addr == 12'h090 && bus_wdata[5]);

    p_quiet_after_done_r10: assert property (@(posedge clk) disable iff (rst)
        done |-> !bus_req);

    p_done_sticky_r10: assert property (@(posedge clk) disable iff (rst)
        done |=> done);

    p_train_err_sticky_r7: assert property (@(posedge clk) disable iff (rst)
        err_train_timeout |=> err_train_timeout);

    p_train_err_early_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(err_train_timeout) |-> !done);

    p_l0_err_ends_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(err_l0_timeout) |-> done);

endmodule

bind link_retrain_seq link_retrain_seq_chk chk_i (.*);

// File: tb/link_retrain_seq_tb_top.sv
`timescale 1ns/1ps
module link_retrain_seq_tb_top;

    localparam int POLL_GAP = 5;
    localparam int TIMEOUT  = 60;
    localparam int LAT      = 2;
    localparam logic [11:0] A_CAP = 12'h08C;
    localparam logic [11:0] A_CTL = 12'h090;
    localparam logic [11:0] A_STA = 12'h092;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [4:0]  ltssm_state;
    logic        bus_req, bus_we, bus_ack;
    logic [11:0] bus_addr;
    logic [15:0] bus_wdata, bus_rdata;
    logic        done, err_train_timeout, err_l0_timeout;

    always #5 clk = ~clk;

    link_retrain_seq #(.POLL_GAP(POLL_GAP), .TIMEOUT(TIMEOUT)) dut_i (
        .clk(clk), .rst(rst), .ltssm_state(ltssm_state),
        .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_ack(bus_ack), .bus_rdata(bus_rdata),
        .done(done), .err_train_timeout(err_train_timeout),
        .err_l0_timeout(err_l0_timeout)
    );

    // scenario configuration
    bit          cfg_up;
    logic [4:0]  cfg_down_code;
    logic [3:0]  cfg_cap, cfg_cur;
    logic [15:0] cfg_ctl;
    int          cfg_ltp, cfg_l0d;

    // register model state
    int          cyc = 0;
    int          lat_cnt, txn, wr_cnt, sta_after, unk, min_sp, prev_t, t_wack, t_errtr;
    bit          have_prev, errtr_seen, req_d;
    logic [15:0] wr_data;
    logic        lt_now;
    logic [15:0] sta_val;

    assign lt_now  = (wr_cnt > 0) && (sta_after < cfg_ltp);
    assign sta_val = {4'h0, lt_now, 7'h00, cfg_cur};
    assign ltssm_state = !cfg_up ? cfg_down_code :
                         ((wr_cnt > 0) && (cfg_l0d < 0 || cyc < t_wack + cfg_l0d)) ? 5'h07 : 5'h0F;

    always @(posedge clk) cyc <= cyc + 1;

    always @(posedge clk) begin
        req_d <= bus_req;
        if (rst) begin
            bus_ack <= 1'b0; bus_rdata <= '0; lat_cnt <= 0; txn <= 0; wr_cnt <= 0;
            wr_data <= '0; sta_after <= 0; unk <= 0; have_prev <= 1'b0;
            min_sp <= 1000000; prev_t <= 0; t_wack <= 0; errtr_seen <= 1'b0; t_errtr <= 0;
        end else begin
            if (bus_req && !req_d && bus_addr == A_STA && wr_cnt > 0) begin
                if (have_prev && (cyc - prev_t) < min_sp) min_sp <= cyc - prev_t;
                prev_t    <= cyc;
                have_prev <= 1'b1;
            end
            if (err_train_timeout && !errtr_seen) begin
                errtr_seen <= 1'b1;
                t_errtr    <= cyc;
            end
            if (bus_ack) begin
                bus_ack <= 1'b0;
                lat_cnt <= 0;
            end else if (bus_req) begin
                if (lat_cnt == LAT) begin
                    bus_ack <= 1'b1;
                    txn     <= txn + 1;
                    if (bus_we) begin
                        bus_rdata <= '0;
                        if (bus_addr == A_CTL) begin
                            wr_cnt  <= wr_cnt + 1;
                            wr_data <= bus_wdata;
                            t_wack  <= cyc;
                        end else begin
                            unk <= unk + 1;
                        end
                    end else begin
                        case (bus_addr)
                            A_CAP: bus_rdata <= {12'h000, cfg_cap};
                            A_STA: begin
                                bus_rdata <= sta_val;
                                if (wr_cnt > 0) sta_after <= sta_after + 1;
                            end
                            A_CTL: bus_rdata <= cfg_ctl;
                            default: begin
                                bus_rdata <= 16'hDEAD;
                                unk       <= unk + 1;
                            end
                        endcase
                    end
                end else begin
                    lat_cnt <= lat_cnt + 1;
                end
            end
        end
    end

    int n_tests = 0;
    int n_fail  = 0;
    bit wd_hit  = 1'b0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic run(input bit up, input logic [4:0] down_code, input logic [3:0] cap,
                       input logic [3:0] cur, input logic [15:0] ctl,
                       input int ltp, input int l0d, output bit finished);
        int n;
        cfg_up = up; cfg_down_code = down_code; cfg_cap = cap; cfg_cur = cur;
        cfg_ctl = ctl; cfg_ltp = ltp; cfg_l0d = l0d;
        @(negedge clk); rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        n = 0;
        while (!done && n < 3000) begin
            @(negedge clk);
            n++;
        end
        finished = done;
    endtask

    task automatic quiet_check(input string tag);
        int t0;
        t0 = txn;
        repeat (20) @(negedge clk);
        chk(done && txn == t0 && !bus_req, tag, txn, t0);
    endtask

    initial begin
        bit fin;
        int exp_txn;
        bit exp_wr;
        cfg_up = 1'b0; cfg_down_code = 5'h03; cfg_cap = 0; cfg_cur = 0;
        cfg_ctl = 0; cfg_ltp = 0; cfg_l0d = 0;

        // reset state
        repeat (2) @(negedge clk);
        chk(!bus_req && !err_train_timeout && !err_l0_timeout, "R5 reset idle", bus_req, 0);

        // R1: link not active, including near-miss codes
        for (int k = 0; k < 3; k++) begin
            logic [4:0] code;
            code = (k == 0) ? 5'h03 : (k == 1) ? 5'h0E : 5'h1F;
            run(1'b0, code, 4'd3, 4'd1, 16'h0043, 2, 8, fin);
            chk(fin, "R1 done when down", fin, 1);
            chk(txn == 0, "R1 no access when down", txn, 0);
            quiet_check("R10 quiet after done");
        end

        // sweep of speed decisions, link active
        for (int cap = 0; cap < 5; cap++) begin
            for (int cur = 1; cur < 4; cur++) begin
                exp_wr  = (cap > 1) && (cur == 1);
                exp_txn = (cap <= 1) ? 1 : (cur != 1) ? 2 : 4 + 3;
                run(1'b1, 5'h03, 4'(cap), 4'(cur), 16'h0A43, 2, 8, fin);
                chk(fin, "R2 R3 done", fin, 1);
                chk(wr_cnt == (exp_wr ? 1 : 0), "R2 R3 write decision", wr_cnt, exp_wr ? 1 : 0);
                chk(txn == exp_txn, "R6 access count", txn, exp_txn);
                chk(unk == 0, "R5 only known addresses", unk, 0);
                chk(!err_train_timeout && !err_l0_timeout, "R6 R8 no error", err_train_timeout, 0);
                if (exp_wr) chk(wr_data == 16'h0A63, "R4 write data", wr_data, 16'h0A63);
                quiet_check("R10 quiet after done");
            end
        end

        // R4: other bits preserved, bit already set
        run(1'b1, 5'h03, 4'd2, 4'd1, 16'hFFDF, 0, 4, fin);
        chk(wr_data == 16'hFFFF, "R4 preserve bits", wr_data, 16'hFFFF);
        chk(txn == 5, "R6 single poll when training clear", txn, 5);
        run(1'b1, 5'h03, 4'd4, 4'd1, 16'h0020, 5, 30, fin);
        chk(wr_data == 16'h0020, "R4 bit already set", wr_data, 16'h0020);
        chk(sta_after == 6, "R6 polls until clear", sta_after, 6);
        chk(fin && !err_train_timeout && !err_l0_timeout, "R8 late active ok", err_l0_timeout, 0);
        chk(min_sp >= POLL_GAP, "R9 poll spacing", min_sp, POLL_GAP);

        // R7: training never ends
        run(1'b1, 5'h03, 4'd3, 4'd1, 16'h0001, 1000000, 8, fin);
        chk(fin && err_train_timeout, "R7 training timeout flag", err_train_timeout, 1);
        chk(!err_l0_timeout, "R7 continues to active wait", err_l0_timeout, 0);
        chk((t_errtr - t_wack) >= TIMEOUT, "R7 not before deadline", t_errtr - t_wack, TIMEOUT);
        chk((t_errtr - t_wack) <= TIMEOUT + POLL_GAP + 2 * LAT + 12, "R7 soon after deadline",
            t_errtr - t_wack, TIMEOUT + POLL_GAP + 2 * LAT + 12);
        chk(min_sp >= POLL_GAP && sta_after >= 2, "R9 spacing during timeout", min_sp, POLL_GAP);
        quiet_check("R10 quiet after timeout");

        // R8: active state never returns
        run(1'b1, 5'h03, 4'd2, 4'd1, 16'h0000, 1, -1, fin);
        chk(fin && err_l0_timeout, "R8 active timeout flag", err_l0_timeout, 1);
        chk(!err_train_timeout, "R8 no training error", err_train_timeout, 0);
        quiet_check("R10 quiet after active timeout");

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #1500000;
        wd_hit = 1'b1;
        n_tests++;
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule